// File: doc/BRIEF.md
# Programmable Clock Divider with Staged Ratio Reload

This block divides its input clock by an integer ratio that software programs through a small memory-mapped register port. There are two registers: a control word and a ratio word. A ratio written to the ratio word goes into a shadow field only, and the divider keeps running at its old ratio. The new ratio is adopted only when software completes a two-step reload. First it sets the per-clock force flag in the control word. Then it raises the global reload trigger in the same word while the force flag is still set.

Once the ratio has been adopted, software clears the request bits. Clearing them leaves the adopted ratio in place. A separate enable bit in a high region of the control word gates the divided output. While that bit is clear the output is held low. Setting it again starts the output at the beginning of a period. Each adoption of a ratio produces a one-cycle `commit_done` pulse.

Top module: `ratio_clkdiv`

## Requirements
- R1: After reset the adopted ratio is 4, `clk_div_out` and `commit_done` are low, and both registers read back as zero.
- R2: A read of the ratio word at byte offset `RATIO_OFS` (8 by default) returns the last value written to it, with the ratio in bits [13:8]. This holds before that value is adopted, and until adoption the output period does not change.
- R3: A ratio is adopted only in the cycle when a control write raises the reload trigger (bit 8) from 0 to 1 and the same write has the force flag (bit 1) set. `commit_done` is high for exactly the one cycle after that write.
- R4: A control write that raises bit 8 while bit 1 is clear adopts nothing, and `commit_done` stays low.
- R5: Clearing control bits [7:0] and bit 8 after an adoption leaves the adopted ratio unchanged.
- R6: With adopted ratio r, and r among 4, 5, 6 and 8, the output stays high for floor(r/2) input cycles and low for r - floor(r/2) input cycles.
- R7: The enable is control bit `EN_BASE`+1, which is bit 25 by default. From the second clock edge after a write clears it, `clk_div_out` is held low.
- R8: After a write sets the enable, the output is low for one cycle. It then stays high for a full floor(r/2) cycles.
- R9: A shadow ratio of 0 or 1 is rejected at the reload. The previous ratio stays in force and `commit_done` stays low.
- R10: At an adoption, the output is low in the cycle after the reload write. A complete period at the new ratio then starts with its high phase.
- R11: A write to any address other than offset 0 or `RATIO_OFS` changes neither register, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided; also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| clk_div_out | output | 1 | Divided and gated output |
| commit_done | output | 1 | One-cycle pulse after a ratio is adopted |

## Verification
The bench builds the block with its default parameters: the ratio word at offset 8, the enable region based at bit 24, and a 6-bit ratio field at bit 8. With that layout, every supported ratio (4, 5, 6 and 8) can be adopted and measured for both phase lengths. Both rejected ratios can be tried, a reload without the force flag can be issued, and the unused offset 4 can be probed to show it is not decoded. Because writes are issued one per cycle, the bench controls the exact order of shadow write, force, trigger and clear. This reaches the edge cases of a trigger without a rising edge and an adoption that restarts the period.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_RATIO = 2'd2
  } reg_sel_e;

  // smallest ratio the divider can realise with a non-empty high phase
  localparam int unsigned MIN_RATIO = 2;

endpackage

// File: rtl/rcd_regs.sv
module rcd_regs
  import rcd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RATIO_OFS = 8,
  parameter int unsigned RATIO_LSB = 8,
  parameter int unsigned RATIO_W   = 6,
  parameter int unsigned TRIG_BIT  = 8,
  parameter int unsigned EN_BIT    = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               ctrl_wr,
  output logic               trig_q,
  output logic               en_q,
  output logic [RATIO_W-1:0] shadow
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
  localparam logic [ADDR_W-1:0] RATIO_ADDR = ADDR_W'(RATIO_OFS);

  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] ratio_q, ratio_d;
  logic              ctrl_en, ratio_en;

  always_comb begin
    if (bus_addr == CTRL_ADDR)       sel = SEL_CTRL;
    else if (bus_addr == RATIO_ADDR) sel = SEL_RATIO;
    else                             sel = SEL_NONE;
  end

  always_comb begin
    ctrl_en  = bus_wr && (sel == SEL_CTRL);
    ratio_en = bus_wr && (sel == SEL_RATIO);
    ctrl_d   = bus_wdata;
    ratio_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ratio_q <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (ratio_en) ratio_q <= ratio_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_RATIO: bus_rdata = ratio_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign ctrl_wr = ctrl_en;
  assign trig_q  = ctrl_q[TRIG_BIT];
  assign en_q    = ctrl_q[EN_BIT];
  assign shadow  = ratio_q[RATIO_LSB +: RATIO_W];

endmodule

// File: rtl/rcd_commit.sv
module rcd_commit
  import rcd_pkg::*;
#(
  parameter int unsigned RATIO_W     = 6,
  parameter int unsigned RESET_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic               wr_force,
  input  logic               wr_trig,
  input  logic               trig_q,
  input  logic [RATIO_W-1:0] shadow,
  output logic               commit_now,
  output logic [RATIO_W-1:0] act_q,
  output logic [RATIO_W-1:0] act_d,
  output logic               done_q
);

  localparam logic [RATIO_W-1:0] RST_VAL = RATIO_W'(RESET_RATIO);
  localparam logic [RATIO_W-1:0] MIN_VAL = RATIO_W'(MIN_RATIO);

  logic trig_rise;
  logic shadow_ok;

  always_comb begin
    trig_rise  = ctrl_wr && wr_trig && !trig_q;
    shadow_ok  = (shadow >= MIN_VAL);
    commit_now = trig_rise && wr_force && shadow_ok;
    act_d      = commit_now ? shadow : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RST_VAL;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      done_q <= commit_now;
    end
  end

endmodule

// File: rtl/rcd_divider.sv
module rcd_divider #(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [RATIO_W-1:0] act_q,
  input  logic [RATIO_W-1:0] act_d,
  output logic               clk_out
);

  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               out_q, out_d;
  logic [RATIO_W-1:0] half;

  always_comb begin
    half = act_q >> 1;
    if (restart || !run) begin
      // park on the last count so the next enabled edge opens a period
      cnt_d = act_d - ONE;
      out_d = 1'b0;
    end else begin
      cnt_d = (cnt_q == act_q - ONE) ? '0 : cnt_q + ONE;
      out_d = (cnt_d < half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_out = out_q;

endmodule

// File: rtl/ratio_clkdiv.sv
module ratio_clkdiv #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned RATIO_OFS   = 8,
  parameter int unsigned EN_BASE     = 24,
  parameter int unsigned FORCE_BIT   = 1,
  parameter int unsigned TRIG_BIT    = 8,
  parameter int unsigned RATIO_LSB   = 8,
  parameter int unsigned RATIO_W     = 6,
  parameter int unsigned RESET_RATIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_div_out,
  output logic              commit_done
);

  localparam int unsigned EN_BIT = EN_BASE + FORCE_BIT;

  logic               ctrl_wr;
  logic               trig_q;
  logic               run;
  logic [RATIO_W-1:0] shadow;
  logic               commit_now;
  logic [RATIO_W-1:0] act_ratio;
  logic [RATIO_W-1:0] act_next;

  rcd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_OFS(RATIO_OFS),
    .RATIO_LSB(RATIO_LSB), .RATIO_W(RATIO_W),
    .TRIG_BIT(TRIG_BIT), .EN_BIT(EN_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ctrl_wr(ctrl_wr), .trig_q(trig_q), .en_q(run), .shadow(shadow)
  );

  rcd_commit #(
    .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
  ) commit_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr),
    .wr_force(bus_wdata[FORCE_BIT]), .wr_trig(bus_wdata[TRIG_BIT]),
    .trig_q(trig_q), .shadow(shadow),
    .commit_now(commit_now), .act_q(act_ratio), .act_d(act_next),
    .done_q(commit_done)
  );

  rcd_divider #(
    .RATIO_W(RATIO_W)
  ) div_i (
    .clk(clk), .rst_n(rst_n),
    .run(run), .restart(commit_now),
    .act_q(act_ratio), .act_d(act_next),
    .clk_out(clk_div_out)
  );

endmodule

// File: rtl/rcd_checker.sv
module rcd_checker #(
  parameter int unsigned RATIO_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [RATIO_W-1:0] act,
  input logic               out,
  input logic               done
);

  logic [RATIO_W-1:0] hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len_q <= '0;
    else if (out) hi_len_q <= hi_len_q + RATIO_W'(1);
    else          hi_len_q <= '0;
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_ratio_moves_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> done);

  a_r9_ratio_usable: assert property (@(posedge clk) disable iff (!rst_n)
    act >= RATIO_W'(2));

  a_r7_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out);

  a_r6_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> (hi_len_q < (act >> 1)));

  a_r10_low_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !out);

endmodule

bind ratio_clkdiv rcd_checker #(.RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .act(act_ratio),
  .out(clk_div_out), .done(commit_done)
);

// File: tb/ratio_clkdiv_tb_top.sv
module ratio_clkdiv_tb_top;

  localparam logic [7:0]  A_CTRL  = 8'h00;
  localparam logic [7:0]  A_RATIO = 8'h08;
  localparam logic [31:0] EN      = 32'h0200_0000;
  localparam logic [31:0] FORCE   = 32'h0000_0002;
  localparam logic [31:0] TRIG    = 32'h0000_0100;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        clk_div_out;
  logic        commit_done;

  int n_chk;
  int n_bad;
  bit finished;

  ratio_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_div_out(clk_div_out), .commit_done(commit_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    for (int i = 0; i < 40 && clk_div_out; i++) @(negedge clk);
    for (int i = 0; i < 40 && !clk_div_out; i++) @(negedge clk);
    for (int i = 0; i < 40 && clk_div_out; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 40 && !clk_div_out; i++) begin lo++; @(negedge clk); end
  endtask

  task automatic expect_period(input int r, input string req);
    int hi, lo;
    measure(hi, lo);
    check(hi == r / 2, req, hi, r / 2);
    check(lo == r - r / 2, req, lo, r - r / 2);
  endtask

  // full staged reload; checks the pulse and the restart when ok is expected
  task automatic reload(input int r, input bit ok);
    wr(A_RATIO, 32'(r) << 8);
    wr(A_CTRL, EN | FORCE);
    wr(A_CTRL, EN | FORCE | TRIG);
    check(commit_done == ok, "R3 pulse after trigger", commit_done, ok);
    if (ok) check(clk_div_out == 1'b0, "R10 low after commit", clk_div_out, 0);
    @(negedge clk);
    check(commit_done == 1'b0, "R3 pulse one cycle", commit_done, 0);
    if (ok) check(clk_div_out == 1'b1, "R10 period opens high", clk_div_out, 1);
    wr(A_CTRL, EN); // R5: clear request bits
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(clk_div_out == 1'b0, "R1 output low", clk_div_out, 0);
    check(commit_done == 1'b0, "R1 no pulse", commit_done, 0);
    rd(A_CTRL, d);
    check(d == 0, "R1 ctrl zero", d, 0);
    rd(A_RATIO, d);
    check(d == 0, "R1 ratio zero", d, 0);
    wr(A_CTRL, EN);
    expect_period(4, "R1 reset ratio 4");
  endtask

  task automatic t_ratios();
    int rs[4] = '{5, 6, 8, 4};
    foreach (rs[k]) begin
      reload(rs[k], 1'b1);
      expect_period(rs[k], "R6 phase lengths");
    end
    reload(5, 1'b1);
    repeat (7) @(negedge clk);
    expect_period(5, "R5 ratio kept after clear");
  endtask

  task automatic t_shadow_readback();
    logic [31:0] d;
    wr(A_RATIO, 32'd6 << 8);
    rd(A_RATIO, d);
    check(d[13:8] == 6, "R2 shadow readback", d[13:8], 6);
    expect_period(5, "R2 not yet adopted");
  endtask

  task automatic t_no_force();
    wr(A_RATIO, 32'd8 << 8);
    wr(A_CTRL, EN | TRIG);
    check(commit_done == 1'b0, "R4 no pulse without force", commit_done, 0);
    wr(A_CTRL, EN);
    expect_period(5, "R4 ratio unchanged");
  endtask

  task automatic t_invalid();
    reload(1, 1'b0);
    expect_period(5, "R9 ratio 1 rejected");
    reload(0, 1'b0);
    expect_period(5, "R9 ratio 0 rejected");
  endtask

  task automatic t_gate();
    int hi;
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      if (clk_div_out) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R7 held low when disabled", hi, 0);
    wr(A_CTRL, EN);
    check(clk_div_out == 1'b0, "R8 low right after enable", clk_div_out, 0);
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 40 && clk_div_out; i++) begin hi++; @(negedge clk); end
    check(hi == 2, "R8 full first high phase", hi, 2);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d);
    check(d == 0, "R11 unmapped reads zero", d, 0);
    rd(A_CTRL, d);
    check(d == EN, "R11 ctrl untouched", d, EN);
    rd(A_RATIO, d);
    check(d == (32'd0 << 8), "R11 ratio untouched", d, 0);
    expect_period(5, "R11 output unaffected");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    bus_addr = '0;
    bus_wr = 1'b0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratios();
    t_shadow_readback();
    t_no_force();
    t_invalid();
    t_gate();
    t_bad_addr();
    summary();
  end

endmodule